// File: doc/BRIEF.md
# X-Tolerant XOR Response Compactor

This block compresses wide test responses before they are compared against the values they should have. Each qualified cycle it takes an N-bit actual response and an N-bit expected response. Every expected bit carries a value and an unknown flag. Both responses pass through the same fixed XOR network, which reduces N bits to M bits. The network also tracks where the unknown flags spread, so any compacted bit that depends on an unknown expected input is excluded from the comparison. When a compacted bit that is still known differs between the two streams, the block raises a one-cycle mismatch pulse and sets a sticky failure flag.

Each input j is wired into the M outputs according to a column pattern. The column patterns are the M-bit values that have exactly M/2 ones (integer division), taken in increasing numeric order. No such pattern covers another. This guarantees that a single wrong response bit is still seen when at most one expected bit is unknown. The largest N this allows is the binomial coefficient C(M, M/2), and an elaboration-time check rejects any larger N. Vectors with more than one unknown bit are still processed, but detection is not guaranteed for them.

Top module: `xtol_compactor`

## Requirements
- R1: Input j is routed to output i exactly when bit i of column pattern j is 1. Pattern j is the j-th M-bit value (counting from 0, in increasing numeric order) whose population count is M/2. For the default M=4 and N=6, the patterns are 3, 5, 6, 9, 10 and 12.
- R2: One cycle after a cycle with inValid high, bit i of outAct equals the XOR of the actVec bits routed to output i.
- R3: One cycle after a cycle with inValid high, bit i of outXMask equals the OR of the expX bits routed to output i. An unknown flag on an input that is not routed to output i leaves bit i of outXMask at 0.
- R4: One cycle after a cycle with inValid high, mismatch is 1 exactly when some output i has outXMask bit i at 0 and the compacted actual bit differs from the compacted expected bit. Differences on masked bits never cause a mismatch.
- R5: If at most one expVal bit is flagged unknown, and actVec differs from expVal in exactly one position that is not the unknown one, then mismatch is 1.
- R6: outValid is inValid delayed by one cycle. After a cycle with inValid low, outAct and outXMask keep their values and mismatch is 0.
- R7: failSticky becomes 1 on the same edge as any mismatch pulse and stays 1 until clear is sampled high. When clear is high, failSticky is 0 on the next cycle, even if a mismatch is being flagged on that same edge.
- R8: While rstN is low, and directly after reset, outValid, outAct, outXMask, mismatch and failSticky are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Synchronous clear of the sticky failure flag |
| inValid | input | 1 | Qualifies the response vectors in this cycle |
| actVec | input | N | Actual response bits |
| expVal | input | N | Expected response values |
| expX | input | N | Per-bit flags marking an expected bit as unknown |
| outValid | output | 1 | Compacted result is valid |
| outAct | output | M | Compacted actual response |
| outXMask | output | M | Compacted bits that depend on an unknown expected input |
| mismatch | output | 1 | One-cycle pulse on a known-bit difference |
| failSticky | output | 1 | Set by any mismatch, held until clear or reset |

## Verification
The hardest case to reach from the ports is a single wrong bit that shares a compacted output with the one unknown input. There the difference survives only on the outputs that the unknown column does not cover. Random traffic rarely lines up an error position, an unknown position and a data background so that masking and the error overlap. The bench therefore sweeps every unknown position, including "no unknown", against every error position, over a changing data background. A second set of vectors has the error sitting on the unknown bit itself, or has two unknown inputs, to confirm that masked differences stay silent.

// File: rtl/xtol_pkg.sv
package xtol_pkg;

  typedef struct packed {
    logic capture;
    logic compare;
  } ctrl_t;

  function automatic int popCount(int v, int width);
    int c;
    c = 0;
    for (int b = 0; b < width; b++) begin
      if (((v >> b) & 1) != 0) c++;
    end
    return c;
  endfunction

  function automatic int binomial(int n, int k);
    int r;
    r = 1;
    for (int i = 0; i < k; i++) begin
      r = (r * (n - i)) / (i + 1);
    end
    return r;
  endfunction

  // idx-th value of width m with m/2 ones, ascending order
  function automatic int colPattern(int m, int idx);
    int cnt;
    cnt = 0;
    for (int v = 0; v < (1 << m); v++) begin
      if (popCount(v, m) == m / 2) begin
        if (cnt == idx) return v;
        cnt++;
      end
    end
    return 0;
  endfunction

endpackage

// File: rtl/xtol_datapath.sv
module xtol_datapath
  import xtol_pkg::*;
#(
  parameter int M = 4,
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_t        strobe,
  input  logic [N-1:0] actVec,
  input  logic [N-1:0] expVal,
  input  logic [N-1:0] expX,
  output logic         missHit,
  output logic [M-1:0] outAct,
  output logic [M-1:0] outXMask
);

  function automatic logic [N-1:0] rowMaskOf(int r);
    logic [N-1:0] res;
    res = '0;
    for (int j = 0; j < N; j++) begin
      res[j] = ((colPattern(M, j) >> r) & 1) != 0;
    end
    return res;
  endfunction

  logic [M-1:0] actC;
  logic [M-1:0] expC;
  logic [M-1:0] xC;

  for (genvar i = 0; i < M; i++) begin : g_row
    localparam logic [N-1:0] SEL = rowMaskOf(i);
    assign actC[i] = ^(actVec & SEL);
    assign expC[i] = ^(expVal & SEL);
    assign xC[i]   = |(expX & SEL);
  end

  assign missHit = strobe.compare & (|((actC ^ expC) & ~xC));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outAct   <= '0;
      outXMask <= '0;
    end else if (strobe.capture) begin
      outAct   <= actC;
      outXMask <= xC;
    end
  end

endmodule

// File: rtl/xtol_ctrl.sv
module xtol_ctrl
  import xtol_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  clear,
  input  logic  inValid,
  input  logic  missHit,
  output ctrl_t strobe,
  output logic  outValid,
  output logic  mismatch,
  output logic  failSticky
);

  assign strobe.capture = inValid;
  assign strobe.compare = inValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      mismatch   <= 1'b0;
      failSticky <= 1'b0;
    end else begin
      outValid <= inValid;
      mismatch <= missHit;
      if (clear) failSticky <= 1'b0;
      else if (missHit) failSticky <= 1'b1;
    end
  end

endmodule

// File: rtl/xtol_compactor.sv
module xtol_compactor
  import xtol_pkg::*;
#(
  parameter int M = 4,
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         inValid,
  input  logic [N-1:0] actVec,
  input  logic [N-1:0] expVal,
  input  logic [N-1:0] expX,
  output logic         outValid,
  output logic [M-1:0] outAct,
  output logic [M-1:0] outXMask,
  output logic         mismatch,
  output logic         failSticky
);

  localparam int MAX_INPUTS = binomial(M, M / 2);

  if (M < 2 || N < 1 || N > MAX_INPUTS) begin : g_sizeBad
    $error("xtol_compactor: N must be between 1 and C(M, M/2)");
  end

  ctrl_t strobe;
  logic  missHit;

  xtol_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clear     (clear),
    .inValid   (inValid),
    .missHit   (missHit),
    .strobe    (strobe),
    .outValid  (outValid),
    .mismatch  (mismatch),
    .failSticky(failSticky)
  );

  xtol_datapath #(.M(M), .N(N)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .actVec  (actVec),
    .expVal  (expVal),
    .expX    (expX),
    .missHit (missHit),
    .outAct  (outAct),
    .outXMask(outXMask)
  );

endmodule

// File: rtl/xtol_checker.sv
module xtol_checker #(
  parameter int M = 4
) (
  input logic         clk,
  input logic         rstN,
  input logic         clear,
  input logic         inValid,
  input logic         outValid,
  input logic [M-1:0] outAct,
  input logic [M-1:0] outXMask,
  input logic         mismatch,
  input logic         failSticky
);

  p_valid_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_valid_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid && !mismatch);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outAct) && $stable(outXMask));

  p_pulse_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    mismatch |-> outValid);

  p_fail_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    !clear |=> (!mismatch || failSticky));

  p_fail_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
    (failSticky && !clear) |=> failSticky);

  p_fail_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> !failSticky);

  p_fail_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failSticky) |-> mismatch);

endmodule

bind xtol_compactor xtol_checker #(.M(M)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clear     (clear),
  .inValid   (inValid),
  .outValid  (outValid),
  .outAct    (outAct),
  .outXMask  (outXMask),
  .mismatch  (mismatch),
  .failSticky(failSticky)
);

// File: tb/xtol_compactor_tb.sv
module xtol_compactor_tb;

  localparam int M = 4;
  localparam int N = 6;
  localparam int ROWS = 8;

  // {actVec, expVal, expX, wantAct, wantX, wantMis}
  typedef struct packed {
    logic [N-1:0] act;
    logic [N-1:0] ev;
    logic [N-1:0] ex;
    logic [M-1:0] wAct;
    logic [M-1:0] wX;
    logic         wMis;
  } row_t;

  localparam row_t TABLE [ROWS] = '{
    '{6'b000001, 6'b000001, 6'b000000, 4'd3,  4'd0,  1'b0},
    '{6'b100000, 6'b100000, 6'b000000, 4'd12, 4'd0,  1'b0},
    '{6'b111111, 6'b111111, 6'b000000, 4'd15, 4'd0,  1'b0},
    '{6'b000011, 6'b000001, 6'b000000, 4'd6,  4'd0,  1'b1},
    '{6'b000011, 6'b000001, 6'b000010, 4'd6,  4'd5,  1'b0},
    '{6'b010100, 6'b010000, 6'b000001, 4'd12, 4'd3,  1'b1},
    '{6'b001000, 6'b001000, 6'b100000, 4'd9,  4'd12, 1'b0},
    '{6'b000100, 6'b000000, 6'b000011, 4'd6,  4'd7,  1'b0}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         clear = 1'b0;
  logic         inValid = 1'b0;
  logic [N-1:0] actVec = '0;
  logic [N-1:0] expVal = '0;
  logic [N-1:0] expX = '0;
  logic         outValid;
  logic [M-1:0] outAct;
  logic [M-1:0] outXMask;
  logic         mismatch;
  logic         failSticky;

  int checks = 0;
  int fails = 0;
  int colTab [N];

  always #4 clk = ~clk;

  xtol_compactor #(.M(M), .N(N)) u_dut (
    .clk(clk), .rstN(rstN), .clear(clear), .inValid(inValid),
    .actVec(actVec), .expVal(expVal), .expX(expX),
    .outValid(outValid), .outAct(outAct), .outXMask(outXMask),
    .mismatch(mismatch), .failSticky(failSticky)
  );

  task automatic check(string req, string what, int got, int want);
    checks++;
    if (got != want) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, want);
    end
  endtask

  function automatic logic [M-1:0] compactOf(logic [N-1:0] v);
    logic [M-1:0] r;
    r = '0;
    for (int j = 0; j < N; j++) if (v[j]) r ^= M'(colTab[j]);
    return r;
  endfunction

  task automatic applyVec(logic [N-1:0] a, logic [N-1:0] e, logic [N-1:0] x);
    @(negedge clk);
    actVec = a; expVal = e; expX = x; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    int k;
    logic [N-1:0] base;
    k = 0;
    for (int v = 0; v < (1 << M); v++) begin
      if ($countones(v) == M / 2 && k < N) begin
        colTab[k] = v;
        k++;
      end
    end

    // R8 reset state
    repeat (3) @(negedge clk);
    check("R8", "outValid in reset", int'(outValid), 0);
    check("R8", "outAct in reset", int'(outAct), 0);
    check("R8", "outXMask in reset", int'(outXMask), 0);
    check("R8", "mismatch in reset", int'(mismatch), 0);
    check("R8", "failSticky in reset", int'(failSticky), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8", "failSticky after reset", int'(failSticky), 0);

    // table walk: R2 R3 R4
    for (int r = 0; r < ROWS; r++) begin
      applyVec(TABLE[r].act, TABLE[r].ev, TABLE[r].ex);
      check("R6", "outValid", int'(outValid), 1);
      check("R2", "outAct table", int'(outAct), int'(TABLE[r].wAct));
      check("R3", "outXMask table", int'(outXMask), int'(TABLE[r].wX));
      check("R4", "mismatch table", int'(mismatch), int'(TABLE[r].wMis));
    end

    // R6 hold while inValid low
    @(negedge clk);
    actVec = 6'b101010; expVal = 6'b000000; expX = 6'b111111;
    @(negedge clk);
    check("R6", "outValid idle", int'(outValid), 0);
    check("R6", "outAct held", int'(outAct), int'(TABLE[ROWS-1].wAct));
    check("R6", "outXMask held", int'(outXMask), int'(TABLE[ROWS-1].wX));
    check("R6", "mismatch idle", int'(mismatch), 0);

    // R1 one-hot columns
    for (int j = 0; j < N; j++) begin
      applyVec(N'(1) << j, N'(1) << j, '0);
      check("R1", "column pattern", int'(outAct), colTab[j]);
      check("R1", "no mismatch on column", int'(mismatch), 0);
    end

    // R5 every X position vs every single error position, R3 X spread
    base = 6'b010110;
    for (int xp = -1; xp < N; xp++) begin
      for (int e = 0; e < N; e++) begin
        logic [N-1:0] xv;
        if (e == xp) continue;
        xv = (xp < 0) ? '0 : (N'(1) << xp);
        base = N'((int'(base) * 5 + 3) & ((1 << N) - 1));
        applyVec(base ^ (N'(1) << e), base, xv);
        check("R5", "single error caught", int'(mismatch), 1);
        check("R3", "single X spread", int'(outXMask),
              (xp < 0) ? 0 : colTab[xp]);
        check("R2", "compacted actual", int'(outAct),
              int'(compactOf(base ^ (N'(1) << e))));
      end
    end

    // R7 sticky behaviour
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    check("R7", "cleared", int'(failSticky), 0);
    applyVec(6'b000001, 6'b000000, 6'b000000);
    check("R7", "set with pulse", int'(failSticky), 1);
    check("R4", "pulse with error", int'(mismatch), 1);
    applyVec(6'b000001, 6'b000001, 6'b000000);
    check("R7", "held on clean", int'(failSticky), 1);
    check("R4", "no pulse clean", int'(mismatch), 0);
    @(negedge clk);
    check("R7", "held idle", int'(failSticky), 1);
    @(negedge clk);
    clear = 1'b1; actVec = 6'b000010; expVal = '0; expX = '0; inValid = 1'b1;
    @(negedge clk);
    clear = 1'b0; inValid = 1'b0;
    check("R7", "clear wins", int'(failSticky), 0);
    check("R4", "pulse during clear", int'(mismatch), 1);
    @(negedge clk);
    check("R7", "stays clear", int'(failSticky), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule